// File: doc/BRIEF.md
# Trimmed Seconds Counter with Cross-Domain Write Status

This block keeps a seconds count in a slow oscillator domain, nominally 32.768 kHz, so that it goes on counting while the rest of the system sleeps. A programmable trim prescaler sets how many slow-clock periods make one count step: the step period is `trim + 1` slow periods, so a trim of 32767 steps once per second on a 32.768 kHz oscillator. The count is 32 bits wide and wraps from all-ones to zero.

Software sees four word registers in the fast system-clock domain. Address 0 returns the current count at any time. Address 1 takes a new count. Address 2 holds the trim. Address 3 is the control/status word. Writes to the count and trim do not take effect at once. Each one crosses into the slow domain through a toggle handshake, and a busy flag for that write shows in the status word until the slow side acknowledges it. A new count is applied at the next step boundary, and the prescaler restarts at that moment. If the counter is not running, the new count is applied as soon as it arrives. The count travels back to the fast domain as a whole-word snapshot that is captured after a change flag has crossed, so a read never returns a mix of old and new bits.

The counter runs only when software has set the enable bit and the block has detected the slow clock. Detection watches the slow clock through a synchronizer, from the fast domain. It asserts after a set number of rising edges and drops when no edge arrives within a timeout counted in fast-clock cycles. Correct crossing requires the fast clock to run at least about eight times faster than the slow clock.

Top module: `toy_seconds_counter`

## Requirements
- R1: After reset, address 0 reads 0, address 2 reads 0, and in the status word (address 3) the enable bit (bit 0), count-busy bit (bit 2) and trim-busy bit (bit 3) read 0.
- R2: While running, the count increases by exactly one every `trim + 1` slow-clock periods.
- R3: The count changes only by a count write while enable (bit 0 of address 3, writable) or clock-detected (bit 1 of address 3, read-only) is 0.
- R4: A write to address 1 sets the count-busy bit (bit 2) from the next fast cycle. The bit clears once the slow domain has loaded the value. The load happens at the next step boundary, and the prescaler restarts there. When the counter is not running, the load happens as soon as the value arrives. After the bit clears, address 0 reads the written value until the next step.
- R5: A write to address 2 sets the trim-busy bit (bit 3) from the next fast cycle until the slow domain holds the new trim. Address 2 reads back the last accepted trim.
- R6: A write to address 1 or address 2 while that register's busy bit is set is ignored, and the pending value is kept.
- R7: The clock-detected bit sets after DET_EDGES slow-clock rising edges. It clears when no rising edge arrives within TIMEOUT fast-clock cycles.
- R8: The count wraps from 0xFFFFFFFF to 0 on the following step.
- R9: Address 0 returns a coherent value. In the fast domain it changes only when a slow-domain update has been signalled, and successive reads while running never go backwards or skip a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| slow_clk | input | 1 | Slow oscillator clock that drives the prescaler and the count |
| bus_addr | input | 2 | Register select: 0 count read, 1 count write, 2 trim, 3 control/status |
| bus_we | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational from bus_addr |

## Verification
The bench writes a second value while a count write or a trim write is still pending. A design that accepted the second value would read back the later number instead of the first. It loads all-ones with trim 0 and checks that the count passes through zero, which catches a counter that saturates or sticks. It checks that a count write completes within one step period plus the crossing delay, both while running and while stopped; a design that waited for a step while stopped would keep its busy bit set forever. It also stops the slow clock, so that a detector without a timeout, or a counter that ignores a dropped detect, would show a status bit that stays set or a count that moves when it should not.

// File: rtl/toy_pkg.sv
package toy_pkg;

  typedef enum logic [1:0] {
    REG_SEC_RD = 2'd0,
    REG_SEC_WR = 2'd1,
    REG_TRIM   = 2'd2,
    REG_CTRL   = 2'd3
  } toy_reg_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_DET_BIT   = 1;
  localparam int CTRL_SBUSY_BIT = 2;
  localparam int CTRL_TBUSY_BIT = 3;

endpackage

// File: rtl/toy_sync.sv
module toy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/toy_wr_xfer.sv
// Carries one write from the fast domain into the slow domain with a toggle
// request, and returns a toggle acknowledge that clears the busy flag.
module toy_wr_xfer #(
  parameter int W = 32
) (
  input  logic         clk_f,
  input  logic         rstf_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic [W-1:0] hold,
  input  logic         clk_s,
  input  logic         rsts_n,
  output logic         s_new,
  input  logic         s_done
);

  logic         req_q, req_d;
  logic [W-1:0] hold_q, hold_d;
  logic         ack_f;
  logic         acc;
  logic         req_s, seen_q;
  logic         ack_s_q, ack_s_d;

  // fast side
  assign acc = wr_req && !busy;

  always_comb begin
    req_d  = req_q ^ acc;
    hold_d = acc ? wr_data : hold_q;
  end

  always_ff @(posedge clk_f or negedge rstf_n) begin
    if (!rstf_n) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  toy_sync u_ack_sync (.clk(clk_f), .rst_n(rstf_n), .d(ack_s_q), .q(ack_f));

  assign busy = req_q ^ ack_f;
  assign hold = hold_q;

  // slow side
  toy_sync u_req_sync (.clk(clk_s), .rst_n(rsts_n), .d(req_q), .q(req_s));

  assign s_new = req_s ^ seen_q;

  always_comb begin
    ack_s_d = ack_s_q ^ s_done;
  end

  always_ff @(posedge clk_s or negedge rsts_n) begin
    if (!rsts_n) begin
      seen_q  <= 1'b0;
      ack_s_q <= 1'b0;
    end else begin
      seen_q  <= req_s;
      ack_s_q <= ack_s_d;
    end
  end

  // R4 R5
  accept_sets_busy_chk: assert property (@(posedge clk_f) disable iff (!rstf_n)
    acc |=> busy);

  // R6
  ignore_while_busy_chk: assert property (@(posedge clk_f) disable iff (!rstf_n)
    (busy && wr_req) |=> $stable(hold_q));

endmodule

// File: rtl/toy_slow_core.sv
// Slow-domain prescaler and seconds count.
module toy_slow_core #(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic              clk_s,
  input  logic              rsts_n,
  input  logic              run_s,
  input  logic              trim_new,
  input  logic [TRIM_W-1:0] trim_data,
  input  logic              cnt_new,
  input  logic [CNT_W-1:0]  cnt_data,
  output logic              trim_done,
  output logic              cnt_done,
  output logic [CNT_W-1:0]  sec,
  output logic              snap_tgl
);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [TRIM_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0]  sec_q, sec_d;
  logic              pend_q, pend_d;
  logic              snap_q, snap_d;
  logic              bnd;
  logic              ld_now;

  assign bnd    = run_s && (pre_q >= trim_q);
  assign ld_now = pend_q && (bnd || !run_s);

  always_comb begin
    trim_d = trim_new ? trim_data : trim_q;

    if (ld_now || bnd) pre_d = '0;
    else if (run_s)    pre_d = pre_q + 1'b1;
    else               pre_d = pre_q;

    if (ld_now)   sec_d = cnt_data;
    else if (bnd) sec_d = sec_q + 1'b1;
    else          sec_d = sec_q;

    if (ld_now)       pend_d = 1'b0;
    else if (cnt_new) pend_d = 1'b1;
    else              pend_d = pend_q;

    snap_d = snap_q ^ (ld_now || bnd);
  end

  always_ff @(posedge clk_s or negedge rsts_n) begin
    if (!rsts_n) begin
      trim_q <= '0;
      pre_q  <= '0;
      sec_q  <= '0;
      pend_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      trim_q <= trim_d;
      pre_q  <= pre_d;
      sec_q  <= sec_d;
      pend_q <= pend_d;
      snap_q <= snap_d;
    end
  end

  assign trim_done = trim_new;
  assign cnt_done  = ld_now;
  assign sec       = sec_q;
  assign snap_tgl  = snap_q;

  // R3
  idle_holds_chk: assert property (@(posedge clk_s) disable iff (!rsts_n)
    (!run_s && !ld_now) |=> $stable(sec_q));

  // R2 R8
  tick_step_chk: assert property (@(posedge clk_s) disable iff (!rsts_n)
    (bnd && !ld_now) |=> (sec_q == CNT_W'($past(sec_q) + 1'b1)));

  // R4
  load_restarts_chk: assert property (@(posedge clk_s) disable iff (!rsts_n)
    ld_now |=> (pre_q == '0 && sec_q == $past(cnt_data)));

endmodule

// File: rtl/toy_clk_detect.sv
// Watches the slow clock from the fast domain.
module toy_clk_detect #(
  parameter int DET_EDGES = 4,
  parameter int TIMEOUT   = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic detected
);

  localparam int EDGE_W = $clog2(DET_EDGES + 1);
  localparam int IDLE_W = $clog2(TIMEOUT + 1);

  logic              sc_s, sc_prev_q;
  logic              rise;
  logic [EDGE_W-1:0] edges_q, edges_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              det_q, det_d;
  logic              expired;

  toy_sync u_sc_sync (.clk(clk), .rst_n(rst_n), .d(slow_clk), .q(sc_s));

  assign rise    = sc_s && !sc_prev_q;
  assign expired = !rise && (idle_q == IDLE_W'(TIMEOUT - 1));

  always_comb begin
    if (rise) begin
      idle_d  = '0;
      edges_d = (edges_q == EDGE_W'(DET_EDGES)) ? edges_q : edges_q + 1'b1;
    end else if (expired) begin
      idle_d  = '0;
      edges_d = '0;
    end else begin
      idle_d  = idle_q + 1'b1;
      edges_d = edges_q;
    end
    det_d = (edges_d == EDGE_W'(DET_EDGES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_prev_q <= 1'b0;
      edges_q   <= '0;
      idle_q    <= '0;
      det_q     <= 1'b0;
    end else begin
      sc_prev_q <= sc_s;
      edges_q   <= edges_d;
      idle_q    <= idle_d;
      det_q     <= det_d;
    end
  end

  assign detected = det_q;

  // R7
  timeout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !detected);

endmodule

// File: rtl/toy_seconds_counter.sv
module toy_seconds_counter
  import toy_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int TRIM_W    = 16,
  parameter int DET_EDGES = 4,
  parameter int TIMEOUT   = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata
);

  logic              rstf_n, rsts_n;
  toy_reg_e          sel;
  logic              wr_sec, wr_trim, wr_ctrl;
  logic              en_q, en_d;
  logic              det;
  logic              run_s;
  logic              sec_busy, trim_busy;
  logic [CNT_W-1:0]  sec_hold;
  logic [TRIM_W-1:0] trim_hold;
  logic              sec_new_s, sec_done_s, trim_new_s, trim_done_s;
  logic [CNT_W-1:0]  sec_s;
  logic              snap_s, snap_f, snap_prev_q;
  logic              snap_edge;
  logic [CNT_W-1:0]  cnt_rd_q, cnt_rd_d;

  // reset release per domain
  toy_sync u_rstf (.clk(clk),      .rst_n(rst_n), .d(1'b1), .q(rstf_n));
  toy_sync u_rsts (.clk(slow_clk), .rst_n(rst_n), .d(1'b1), .q(rsts_n));

  // register decode
  assign sel     = toy_reg_e'(bus_addr);
  assign wr_sec  = bus_we && (sel == REG_SEC_WR);
  assign wr_trim = bus_we && (sel == REG_TRIM);
  assign wr_ctrl = bus_we && (sel == REG_CTRL);

  always_comb begin
    en_d = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en_q;
  end

  // clock presence
  toy_clk_detect #(.DET_EDGES(DET_EDGES), .TIMEOUT(TIMEOUT)) u_det (
    .clk(clk), .rst_n(rstf_n), .slow_clk(slow_clk), .detected(det));

  toy_sync u_run_sync (.clk(slow_clk), .rst_n(rsts_n), .d(en_q && det), .q(run_s));

  // write crossings
  toy_wr_xfer #(.W(CNT_W)) u_sec_xfer (
    .clk_f(clk), .rstf_n(rstf_n), .wr_req(wr_sec), .wr_data(bus_wdata),
    .busy(sec_busy), .hold(sec_hold),
    .clk_s(slow_clk), .rsts_n(rsts_n), .s_new(sec_new_s), .s_done(sec_done_s));

  toy_wr_xfer #(.W(TRIM_W)) u_trim_xfer (
    .clk_f(clk), .rstf_n(rstf_n), .wr_req(wr_trim), .wr_data(bus_wdata[TRIM_W-1:0]),
    .busy(trim_busy), .hold(trim_hold),
    .clk_s(slow_clk), .rsts_n(rsts_n), .s_new(trim_new_s), .s_done(trim_done_s));

  // slow domain
  toy_slow_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
    .clk_s(slow_clk), .rsts_n(rsts_n), .run_s(run_s),
    .trim_new(trim_new_s), .trim_data(trim_hold),
    .cnt_new(sec_new_s), .cnt_data(sec_hold),
    .trim_done(trim_done_s), .cnt_done(sec_done_s),
    .sec(sec_s), .snap_tgl(snap_s));

  // count snapshot back to the fast domain
  toy_sync u_snap_sync (.clk(clk), .rst_n(rstf_n), .d(snap_s), .q(snap_f));

  assign snap_edge = snap_f ^ snap_prev_q;

  always_comb begin
    cnt_rd_d = snap_edge ? sec_s : cnt_rd_q;
  end

  always_ff @(posedge clk or negedge rstf_n) begin
    if (!rstf_n) begin
      en_q        <= 1'b0;
      snap_prev_q <= 1'b0;
      cnt_rd_q    <= '0;
    end else begin
      en_q        <= en_d;
      snap_prev_q <= snap_f;
      cnt_rd_q    <= cnt_rd_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_SEC_RD: bus_rdata = cnt_rd_q;
      REG_TRIM:   bus_rdata = CNT_W'(trim_hold);
      REG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]    = en_q;
        bus_rdata[CTRL_DET_BIT]   = det;
        bus_rdata[CTRL_SBUSY_BIT] = sec_busy;
        bus_rdata[CTRL_TBUSY_BIT] = trim_busy;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstf_n)
    !snap_edge |=> $stable(cnt_rd_q));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstf_n)
    (!en_q && !wr_ctrl) |=> !en_q);

endmodule

// File: tb/toy_seconds_counter_tb.sv
`timescale 1ns/1ps
module toy_seconds_counter_tb;

  localparam real SLOW_HALF = 100.0;  // slow period = 40 fast cycles
  localparam int  SLOW_P    = 40;

  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        slow_run = 1'b1;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    string       tag;
    logic [1:0]  addr;
    logic [31:0] mask;
    logic [31:0] lo;
    logic [31:0] hi;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always begin
    #(SLOW_HALF);
    if (slow_run) slow_clk = ~slow_clk;
  end

  toy_seconds_counter #(.DET_EDGES(4), .TIMEOUT(300)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t        it;
        logic [31:0] v;
        it = sb_q.pop_front();
        v  = bus_rdata & it.mask;
        n_checks++;
        if ((v - it.lo) > (it.hi - it.lo)) begin
          n_fail++;
          $display("FAIL %s: addr %0d actual %h expected %h..%h",
                   it.tag, it.addr, v, it.lo, it.hi);
        end
      end
    end
  end

  task automatic expect_rd(input string tag, input logic [1:0] a,
                           input logic [31:0] mask, input logic [31:0] lo,
                           input logic [31:0] hi);
    exp_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.tag = tag; it.addr = a; it.mask = mask; it.lo = lo; it.hi = hi;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input bit ok,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic wait_clear(input int bitpos, output int cycles);
    logic [31:0] v;
    cycles = 0;
    rd(2'd3, v);
    while (v[bitpos] && cycles < 5000) begin
      rd(2'd3, v);
      cycles++;
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] c0, c1, v;
    int cyc;
    bit mono;
    rst_n = 1'b0; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    expect_rd("R1 count", 2'd0, 32'hFFFF_FFFF, 32'd0, 32'd0);
    expect_rd("R1 trim",  2'd2, 32'hFFFF_FFFF, 32'd0, 32'd0);
    expect_rd("R1 status", 2'd3, 32'hD, 32'd0, 32'd0);

    // R7 detection after slow edges
    repeat (10 * SLOW_P) @(posedge clk);
    expect_rd("R7 detected", 2'd3, 32'h2, 32'h2, 32'h2);
    expect_rd("R3 no count while disabled", 2'd0, 32'hFFFF_FFFF, 32'd0, 32'd0);

    // R5 trim busy, R6 second write ignored
    wr(2'd2, 32'd9);
    expect_rd("R5 trim busy set", 2'd3, 32'h8, 32'h8, 32'h8);
    wr(2'd2, 32'd5);
    wait_clear(3, cyc);
    expect_rd("R6 trim write while busy ignored", 2'd2, 32'hFFFF_FFFF, 32'd9, 32'd9);
    expect_rd("R5 trim busy cleared", 2'd3, 32'h8, 32'h0, 32'h0);

    // R2 rate with trim 9
    wr(2'd3, 32'd1);
    repeat (20) @(posedge clk);
    rd(2'd0, c0);
    repeat (100 * SLOW_P) @(posedge clk);
    expect_rd("R2 ten steps at trim 9", 2'd0, 32'hFFFF_FFFF, c0 + 9, c0 + 11);

    // R4 count write while running
    wr(2'd1, 32'd1000);
    expect_rd("R4 count busy set", 2'd3, 32'h4, 32'h4, 32'h4);
    wait_clear(2, cyc);
    chk("R4 load within one step", cyc <= 15 * SLOW_P, cyc, 15 * SLOW_P);
    expect_rd("R4 loaded value", 2'd0, 32'hFFFF_FFFF, 32'd1000, 32'd1000);

    // R6 count write while busy ignored
    wr(2'd1, 32'd2000);
    wr(2'd1, 32'd3000);
    wait_clear(2, cyc);
    expect_rd("R6 count write while busy ignored", 2'd0, 32'hFFFF_FFFF, 32'd2000, 32'd2000);

    // R2 rate with trim 0
    wr(2'd2, 32'd0);
    wait_clear(3, cyc);
    rd(2'd0, c0);
    repeat (50 * SLOW_P) @(posedge clk);
    expect_rd("R2 one step per period at trim 0", 2'd0, 32'hFFFF_FFFF, c0 + 49, c0 + 51);

    // R9 successive reads never jump
    rd(2'd0, c0);
    mono = 1'b1;
    for (int i = 0; i < 400; i++) begin
      rd(2'd0, c1);
      if (c1 != c0 && c1 != c0 + 1) mono = 1'b0;
      c0 = c1;
    end
    chk("R9 coherent monotone reads", mono, {31'd0, mono}, 32'd1);

    // R8 wrap
    wr(2'd1, 32'hFFFF_FFFF);
    wait_clear(2, cyc);
    expect_rd("R8 all-ones loaded", 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (4 * SLOW_P) @(posedge clk);
    expect_rd("R8 wrapped past zero", 2'd0, 32'hFFFF_FFFF, 32'd2, 32'd5);

    // R3 disable freezes count; R4 immediate load when stopped
    wr(2'd3, 32'd0);
    repeat (5 * SLOW_P) @(posedge clk);
    rd(2'd0, c0);
    repeat (40 * SLOW_P) @(posedge clk);
    expect_rd("R3 frozen while disabled", 2'd0, 32'hFFFF_FFFF, c0, c0);
    wr(2'd1, 32'd77);
    wait_clear(2, cyc);
    chk("R4 load while stopped completes", cyc <= 8 * SLOW_P, cyc, 8 * SLOW_P);
    expect_rd("R4 value loaded while stopped", 2'd0, 32'hFFFF_FFFF, 32'd77, 32'd77);

    // R7 clock loss and return
    wr(2'd3, 32'd1);
    repeat (5 * SLOW_P) @(posedge clk);
    slow_run = 1'b0;
    repeat (600) @(posedge clk);
    expect_rd("R7 detect drops on timeout", 2'd3, 32'h2, 32'h0, 32'h0);
    rd(2'd0, c0);
    repeat (400) @(posedge clk);
    expect_rd("R3 frozen without clock", 2'd0, 32'hFFFF_FFFF, c0, c0);
    slow_run = 1'b1;
    repeat (10 * SLOW_P) @(posedge clk);
    expect_rd("R7 detect returns", 2'd3, 32'h2, 32'h2, 32'h2);
    expect_rd("R3 resumes counting", 2'd0, 32'hFFFF_FFFF, c0 + 1, c0 + 10);
    rd(2'd3, v);
    chk("R1 enable bit holds written value", v[0] == 1'b1, v[0], 32'd1);

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule